// File: doc/BRIEF.md
# Page Transfer Sequencer

This block sits inside one bank of data memory. It moves whole pages between the bank's word storage and the node controller that does the paging. It also keeps the bank's page table. There is one entry for each physical page. An entry holds a 32-bit virtual base, 32 status bits, a present flag and four tag bits for each word of the page. The tag bits are named P, T, U and V.

A page-out streams the tag bits and then every data word, one beat per cycle. The receiver must take every beat on the cycle it appears, because the bank never stalls. A page-in takes a command beat and a tag beat, then the data words on the cycles that follow. It writes the words into storage and the tags into the page-table entry, but only if that entry already exists. Every operation ends with a single completion pulse. The pulse carries an acknowledge, an entry's contents, or an event.

A parameter selects a read-only variant. That variant keeps no tag bits, so a page-in is only the data words, and page-out is refused. The word storage lives outside this module and is reached through a write port and a read port whose read data returns in the same cycle.

Top module: `page_xfer_seq`

## Requirements
- R1: After reset there is no stream beat, no completion pulse and no storage write, and every page-table entry is absent.
- R2: Command codes on `cmd_op` are 0 map, 1 unmap, 2 read entry, 3 page-out and 4 page-in. Map takes the virtual base from `in_data[31:0]` and the status from `in_data[63:32]`, clears the entry's tags and marks it present. Unmap marks the entry absent. Read of a present entry returns `{status, base}` on `done_data`. Completion codes on `done_kind` are 0 ack, 1 data and 2 event. Map, unmap and read complete in the cycle after acceptance: map and unmap with an ack, read with data for a present entry and with an event for an absent one.
- R3: A page-out of a present entry puts out WORDS+2 beats on consecutive cycles, starting the cycle after acceptance. Beat 0 carries P in bits [WORDS-1:0] and T in bits [2*WORDS-1:WORDS]. Beat 1 carries U and V in the same positions. The remaining beats carry data words 0 to WORDS-1 in ascending order. An ack follows in the cycle after the last beat.
- R4: A page-in of a present entry takes P and T from the command beat and U and V from the next beat, using the positions of R3. It then takes WORDS data words, writes each one to storage in ascending word order, and acks in the cycle after the last beat. A later page-out gives the same tags and words back.
- R5: A page-in to an absent entry writes nothing to storage. It still takes up its full beat count, discarding the beats, and completes with an event in the cycle after its last beat.
- R6: A page-out of an absent entry produces no beats and completes with an event in the cycle after acceptance.
- R7: While a transfer is in progress, every new command is ignored, and the stream in progress is not disturbed.
- R8: A command presented in the same cycle as the completion pulse of a transfer is accepted.
- R9: With the read-only variant, a page-in is exactly WORDS beats, and the command beat carries word 0. Page-out completes at once with an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present on this cycle |
| cmd_op | input | 3 | Command code (R2) |
| cmd_page | input | $clog2(PAGES) | Physical page number |
| in_data | input | DATA_W | Command operand, or the current page-in beat |
| mem_we | output | 1 | Storage write enable |
| mem_addr | output | $clog2(PAGES)+$clog2(WORDS) | Storage word address, {page, word} |
| mem_wdata | output | DATA_W | Storage write data |
| mem_rdata | input | DATA_W | Storage read data for mem_addr, same cycle |
| out_valid | output | 1 | Page-out beat present |
| out_data | output | DATA_W | Page-out beat |
| done_valid | output | 1 | Operation completed |
| done_kind | output | 2 | Completion code (R2) |
| done_data | output | 64 | Entry contents for a read |

## Verification
Two things can fall in the same cycle: the completion pulse of a finished transfer and the acceptance of the next command. The bench provokes this by presenting a page-out during the cycle that shows a page-in's ack. It judges the result by the ack in that cycle and by a complete, correct stream starting one cycle later. The bench also overlaps a command with a stream in progress, one beat into the middle of a page-out. There it checks that the beats run on unchanged and that the ignored map left its target page absent.

// File: rtl/page_xfer_seq.sv
module page_xfer_seq #(
  parameter int DATA_W = 128,
  parameter int WORDS  = 64,
  parameter int PAGES  = 128,
  parameter int TAGGED = 1
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     cmd_valid,
  input  logic [2:0]                               cmd_op,
  input  logic [$clog2(PAGES)-1:0]                 cmd_page,
  input  logic [DATA_W-1:0]                        in_data,
  output logic                                     mem_we,
  output logic [$clog2(PAGES)+$clog2(WORDS)-1:0]   mem_addr,
  output logic [DATA_W-1:0]                        mem_wdata,
  input  logic [DATA_W-1:0]                        mem_rdata,
  output logic                                     out_valid,
  output logic [DATA_W-1:0]                        out_data,
  output logic                                     done_valid,
  output logic [1:0]                               done_kind,
  output logic [63:0]                              done_data
);
  localparam int PW       = $clog2(PAGES);
  localparam int WW       = $clog2(WORDS);
  localparam bit HAS_TAGS = (TAGGED != 0);
  localparam int HDR      = HAS_TAGS ? 2 : 0;
  localparam int NBEATS   = WORDS + HDR;
  localparam int CW       = $clog2(NBEATS + 1);

  localparam logic [2:0] OP_MAP = 3'd0, OP_UNMAP = 3'd1, OP_READ = 3'd2, OP_OUT = 3'd3, OP_IN = 3'd4;
  localparam logic [1:0] K_ACK = 2'd0, K_DATA = 2'd1, K_EVENT = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_OUT, S_IN, S_DROP} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [PW-1:0]   pg;
  logic            pt_valid [PAGES];
  logic [31:0]     pt_base  [PAGES];
  logic [31:0]     pt_stat  [PAGES];
  logic [WORDS-1:0] pt_p [PAGES], pt_t [PAGES], pt_u [PAGES], pt_v [PAGES];

  logic          take, hit, last;
  logic [WW-1:0] widx;

  assign take = cmd_valid && (st == S_IDLE);
  assign hit  = pt_valid[cmd_page];
  assign last = (cnt == CW'(NBEATS - 1));
  assign widx = WW'(cnt - CW'(HDR));

  assign mem_we    = (take && cmd_op == OP_IN && hit && !HAS_TAGS)
                  || (st == S_IN && cnt >= CW'(HDR));
  assign mem_addr  = (st == S_IDLE) ? {cmd_page, WW'(0)} : {pg, widx};
  assign mem_wdata = in_data;
  assign out_valid = (st == S_OUT);

  always_comb begin
    out_data = '0;
    if (out_valid) begin
      if (HAS_TAGS && cnt == CW'(0)) begin
        out_data[WORDS-1:0]       = pt_p[pg];
        out_data[2*WORDS-1:WORDS] = pt_t[pg];
      end else if (HAS_TAGS && cnt == CW'(1)) begin
        out_data[WORDS-1:0]       = pt_u[pg];
        out_data[2*WORDS-1:WORDS] = pt_v[pg];
      end else begin
        out_data = mem_rdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      pg         <= '0;
      done_valid <= 1'b0;
      done_kind  <= K_ACK;
      done_data  <= '0;
      for (int i = 0; i < PAGES; i++) pt_valid[i] <= 1'b0;
    end else begin
      done_valid <= 1'b0;
      if (take) begin
        pg <= cmd_page;
        case (cmd_op)
          OP_MAP:   begin pt_valid[cmd_page] <= 1'b1; done_valid <= 1'b1; done_kind <= K_ACK; end
          OP_UNMAP: begin pt_valid[cmd_page] <= 1'b0; done_valid <= 1'b1; done_kind <= K_ACK; end
          OP_READ: begin
            done_valid <= 1'b1;
            done_kind  <= hit ? K_DATA : K_EVENT;
            done_data  <= {pt_stat[cmd_page], pt_base[cmd_page]};
          end
          OP_OUT: begin
            if (hit && HAS_TAGS) begin
              st  <= S_OUT;
              cnt <= '0;
            end else begin
              done_valid <= 1'b1;
              done_kind  <= K_EVENT;
            end
          end
          OP_IN: begin
            st  <= hit ? S_IN : S_DROP;
            cnt <= CW'(1);
          end
          default: ;
        endcase
      end else if (st != S_IDLE) begin
        if (last) begin
          st         <= S_IDLE;
          cnt        <= '0;
          done_valid <= 1'b1;
          done_kind  <= (st == S_DROP) ? K_EVENT : K_ACK;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take && cmd_op == OP_MAP) begin
      pt_base[cmd_page] <= in_data[31:0];
      pt_stat[cmd_page] <= in_data[63:32];
      pt_p[cmd_page] <= '0;
      pt_t[cmd_page] <= '0;
      pt_u[cmd_page] <= '0;
      pt_v[cmd_page] <= '0;
    end
    if (HAS_TAGS && take && cmd_op == OP_IN && hit) begin
      pt_p[cmd_page] <= in_data[WORDS-1:0];
      pt_t[cmd_page] <= in_data[2*WORDS-1:WORDS];
    end
    if (HAS_TAGS && st == S_IN && cnt == CW'(1)) begin
      pt_u[pg] <= in_data[WORDS-1:0];
      pt_v[pg] <= in_data[2*WORDS-1:WORDS];
    end
  end

  assert_stream_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(cmd_valid && cmd_op == OP_OUT));

  assert_stream_end_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> (done_valid && done_kind == K_ACK));

  assert_write_mapped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> pt_valid[mem_addr[PW+WW-1:WW]]);

  assert_drop_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DROP) |-> !mem_we);

  assert_busy_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && st != S_IDLE && !last) |=> (st == $past(st)));

  assert_stream_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !mem_we);
endmodule

// File: tb/page_xfer_seq_test.sv
module page_xfer_seq_test;
  localparam int DW = 128, WD = 64, NP = 4, PW = 2, AW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          cmd_valid = 0, r_cmd_valid = 0;
  logic [2:0]    cmd_op = 0;
  logic [PW-1:0] cmd_page = 0;
  logic [DW-1:0] in_data = 0;

  logic mem_we, out_valid, done_valid, r_mem_we, r_out_valid, r_done_valid;
  logic [AW-1:0] mem_addr, r_mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, out_data, r_mem_wdata, r_mem_rdata, r_out_data;
  logic [1:0]    done_kind, r_done_kind;
  logic [63:0]   done_data, r_done_data;

  logic [DW-1:0] mem [256];
  logic [DW-1:0] mem_ro [256];
  logic [WD-1:0] ep [NP], et [NP], eu [NP], ev [NP];

  int n_chk = 0, n_bad = 0;

  function automatic logic [DW-1:0] init_word(int a);
    return {4{32'h5A00_0000 | 32'(a)}};
  endfunction
  function automatic logic [DW-1:0] gw(int pg, int i, int seed);
    return {4{seed[15:0], pg[7:0], i[7:0]}};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin mem[i] <= init_word(i); mem_ro[i] <= init_word(i); end
    end else begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (r_mem_we) mem_ro[r_mem_addr] <= r_mem_wdata;
    end
  end
  assign mem_rdata   = mem[mem_addr];
  assign r_mem_rdata = mem_ro[r_mem_addr];

  page_xfer_seq #(.DATA_W(DW), .WORDS(WD), .PAGES(NP), .TAGGED(1)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_page(cmd_page),
    .in_data(in_data), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data),
    .done_valid(done_valid), .done_kind(done_kind), .done_data(done_data));

  page_xfer_seq #(.DATA_W(DW), .WORDS(WD), .PAGES(NP), .TAGGED(0)) uut_ro (
    .clk(clk), .rst_n(rst_n), .cmd_valid(r_cmd_valid), .cmd_op(cmd_op), .cmd_page(cmd_page),
    .in_data(in_data), .mem_we(r_mem_we), .mem_addr(r_mem_addr), .mem_wdata(r_mem_wdata),
    .mem_rdata(r_mem_rdata), .out_valid(r_out_valid), .out_data(r_out_data),
    .done_valid(r_done_valid), .done_kind(r_done_kind), .done_data(r_done_data));

  task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send(input int op, input int pg, input logic [DW-1:0] d, input bit ro);
    cmd_op = 3'(op); cmd_page = PW'(pg); in_data = d;
    if (ro) r_cmd_valid = 1; else cmd_valid = 1;
    tick();
    cmd_valid = 0; r_cmd_valid = 0;
  endtask

  task automatic expect_done(input string req, input int kind);
    #2;
    chk(req, "done_valid", DW'(done_valid), DW'(1));
    chk(req, "done_kind", DW'(done_kind), DW'(kind));
  endtask

  function automatic logic [DW-1:0] exp_beat(int pg, int b);
    if (b == 0) return {et[pg], ep[pg]};
    if (b == 1) return {ev[pg], eu[pg]};
    return mem[pg*WD + b - 2];
  endfunction

  task automatic expect_stream(input string req, input int pg, input bit inject);
    for (int b = 0; b < WD + 2; b++) begin
      if (inject && b == 10) begin
        cmd_valid = 1; cmd_op = 3'd0; cmd_page = PW'(3); in_data = DW'(64'hFFFF_0000_1111_2222);
      end else cmd_valid = 0;
      #2;
      chk(req, "out_valid", DW'(out_valid), DW'(1));
      chk(req, $sformatf("beat %0d", b), out_data, exp_beat(pg, b));
      tick();
    end
    cmd_valid = 0;
    #2 chk(req, "out_valid after end", DW'(out_valid), DW'(0));
    chk(req, "done after stream", DW'({done_valid, done_kind}), DW'({1'b1, 2'd0}));
  endtask

  task automatic drive_in(input int pg, input int seed, input bit ro);
    int n = ro ? WD : WD + 2;
    cmd_op = 3'd4; cmd_page = PW'(pg);
    for (int b = 0; b < n; b++) begin
      if (ro) in_data = gw(pg, b, seed);
      else if (b == 0) in_data = {{32'h7000_0000 + seed}, {32'h3000_0000 + seed}, {32'h2000_0000 + seed}, {32'h1000_0000 + seed}};
      else if (b == 1) in_data = {{32'hF000_0000 + seed}, {32'hB000_0000 + seed}, {32'hA000_0000 + seed}, {32'h9000_0000 + seed}};
      else in_data = gw(pg, b - 2, seed);
      if (ro) r_cmd_valid = (b == 0); else cmd_valid = (b == 0);
      tick();
    end
    cmd_valid = 0; r_cmd_valid = 0;
  endtask

  task automatic set_tags(input int pg, input int seed);
    ep[pg] = {32'h2000_0000 + seed, 32'h1000_0000 + seed};
    et[pg] = {32'h7000_0000 + seed, 32'h3000_0000 + seed};
    eu[pg] = {32'hA000_0000 + seed, 32'h9000_0000 + seed};
    ev[pg] = {32'hF000_0000 + seed, 32'hB000_0000 + seed};
  endtask

  task automatic t_reset();
    #2;
    chk("R1", "out_valid", DW'(out_valid), DW'(0));
    chk("R1", "done_valid", DW'(done_valid), DW'(0));
    chk("R1", "mem_we", DW'(mem_we), DW'(0));
    for (int p = 0; p < NP; p++) begin
      tick(); send(2, p, '0, 0); expect_done("R1", 2);
    end
  endtask

  task automatic t_map();
    tick(); send(0, 0, DW'(64'hCAFE_0001_0040_0000), 0); expect_done("R2", 0);
    tick(); send(2, 0, '0, 0); expect_done("R2", 1);
    chk("R2", "entry data", DW'(done_data), DW'(64'hCAFE_0001_0040_0000));
    tick(); send(1, 0, '0, 0); expect_done("R2", 0);
    tick(); send(2, 0, '0, 0); expect_done("R2", 2);
    tick(); send(0, 0, DW'(64'h0000_0002_0080_0000), 0); expect_done("R2", 0);
    tick(); send(0, 1, DW'(64'h0000_0003_00C0_0000), 0); expect_done("R2", 0);
    for (int p = 0; p < NP; p++) begin ep[p] = '0; et[p] = '0; eu[p] = '0; ev[p] = '0; end
  endtask

  task automatic t_pgout_clean();
    tick(); send(3, 0, '0, 0);
    expect_stream("R3", 0, 0);
  endtask

  task automatic t_pgin();
    tick(); drive_in(1, 5, 0); set_tags(1, 5);
    expect_done("R4", 0);
    for (int i = 0; i < WD; i++) chk("R4", "stored word", mem[WD + i], gw(1, i, 5));
    tick(); send(3, 1, '0, 0);
    expect_stream("R4", 1, 0);
  endtask

  task automatic t_pgin_missing();
    tick(); drive_in(2, 9, 0);
    expect_done("R5", 2);
    for (int i = 0; i < WD; i++) chk("R5", "untouched word", mem[2*WD + i], init_word(2*WD + i));
  endtask

  task automatic t_pgout_missing();
    tick(); send(3, 2, '0, 0);
    expect_done("R6", 2);
    chk("R6", "no beat", DW'(out_valid), DW'(0));
  endtask

  task automatic t_busy();
    tick(); send(3, 1, '0, 0);
    expect_stream("R7", 1, 1);
    tick(); send(2, 3, '0, 0); expect_done("R7", 2);
  endtask

  task automatic t_b2b();
    tick(); drive_in(1, 12, 0); set_tags(1, 12);
    cmd_valid = 1; cmd_op = 3'd3; cmd_page = PW'(1); in_data = '0;
    expect_done("R8", 0);
    tick(); cmd_valid = 0;
    expect_stream("R8", 1, 0);
  endtask

  task automatic t_ro();
    tick(); send(0, 0, DW'(64'h1), 1);
    #2 chk("R9", "map ack", DW'({r_done_valid, r_done_kind}), DW'({1'b1, 2'd0}));
    tick(); drive_in(0, 33, 1);
    #2 chk("R9", "page-in ack after WORDS beats", DW'({r_done_valid, r_done_kind}), DW'({1'b1, 2'd0}));
    for (int i = 0; i < WD; i++) chk("R9", "stored word", mem_ro[i], gw(0, i, 33));
    tick(); send(3, 0, '0, 1);
    #2 chk("R9", "page-out refused", DW'({r_done_valid, r_done_kind}), DW'({1'b1, 2'd2}));
    chk("R9", "no beat", DW'(r_out_valid), DW'(0));
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_map();
    t_pgout_clean();
    t_pgin();
    t_pgin_missing();
    t_pgout_missing();
    t_busy();
    t_b2b();
    t_ro();
    tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule